// File: doc/BRIEF.md
# Write-Through Store Queue

This block sits between a write-through cache and lower memory. Every processor store that updates the cache is also written into a small in-order queue as an address, data and byte-enable entry. The processor then carries on at once and does not wait for memory. Lower memory removes entries whenever it is ready, through a valid/ready handshake. Its pace is independent of the processor. Evicted dirty blocks from a write-back cache can be queued the same way, so a replacement does not wait on memory.

If every slot is occupied and nothing drains in that cycle, the block raises a stall. The processor holds its store until a slot frees up. A read miss presents its address on a separate check port. If any pending entry carries that address, the block raises a hold so that the read cannot overtake the buffered write. An empty flag lets fence or flush logic wait until every pending write has reached memory.

Top module: `store_queue`

## Requirements
- R1: After reset the queue is empty: `empty`=1, `mem_valid`=0 and `stall`=0.
- R2: A store presented while `stall`=0 is accepted at that clock edge. When the queue was empty before it, the store appears on `mem_valid`/`mem_addr`/`mem_data` right after that edge.
- R3: Entries leave in the order they were accepted, one entry per edge at which `mem_valid` and `mem_ready` are both 1.
- R4: While `mem_valid`=1 and `mem_ready`=0, the presented entry (`mem_addr`, `mem_data`, `mem_be`) stays unchanged.
- R5: `stall` is 1 exactly when all DEPTH slots are occupied and no drain happens in the same cycle. A store presented while `stall`=1 is not queued.
- R6: When the queue is full and a drain happens in the same cycle, `stall` is 0 and a store presented in that cycle is accepted. The queue stays full.
- R7: `rd_hold` is 1 in the same cycle as `rd_chk_valid`=1 whenever any pending entry has an address equal to `rd_chk_addr`. It returns to 0 right after the edge at which the last such entry drains.
- R8: Two stores to the same address occupy two entries. Both drain, in order, with their own data.
- R9: `empty` is 1 exactly when no entry is pending.
- R10: Each entry carries its 4-bit byte enable unchanged to `mem_be`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Processor store request |
| wr_addr | input | AW | Store address |
| wr_data | input | DW | Store data |
| wr_be | input | DW/8 | Store byte enables |
| stall | output | 1 | Queue full, processor must hold the store |
| mem_valid | output | 1 | Head entry offered to memory |
| mem_ready | input | 1 | Memory accepts the head entry |
| mem_addr | output | AW | Head entry address |
| mem_data | output | DW | Head entry data |
| mem_be | output | DW/8 | Head entry byte enables |
| rd_chk_valid | input | 1 | Read-miss address is being checked |
| rd_chk_addr | input | AW | Read-miss address |
| rd_hold | output | 1 | Matching write pending, read must wait |
| empty | output | 1 | No pending entries |

## Verification
`stall` and `rd_hold` are combinational. They are due in the same cycle as the inputs that cause them. An accepted store, or a drained entry, shows on `mem_valid`, `empty` and `rd_hold` one clock edge later. The bench drives every input on the falling edge. It samples combinational results 1 ns after driving and registered results at the next falling edge. As a result, each check lands half a cycle away from the edge that produced the value.

// File: rtl/store_queue.sv
module store_queue #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int BEW   = DW / 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_valid,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [BEW-1:0] wr_be,
  output logic           stall,
  output logic           mem_valid,
  input  logic           mem_ready,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_data,
  output logic [BEW-1:0] mem_be,
  input  logic           rd_chk_valid,
  input  logic [AW-1:0]  rd_chk_addr,
  output logic           rd_hold,
  output logic           empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [AW-1:0]  addr_q [DEPTH];
  logic [DW-1:0]  data_q [DEPTH];
  logic [BEW-1:0] be_q   [DEPTH];
  logic [DEPTH-1:0] vld, vld_nxt, hit;
  logic [PW-1:0] head, tail;
  logic push, pop;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign mem_valid = vld[head];
  assign mem_addr  = addr_q[head];
  assign mem_data  = data_q[head];
  assign mem_be    = be_q[head];
  assign pop       = mem_valid & mem_ready;
  assign stall     = (&vld) & ~pop;
  assign push      = wr_valid & ~stall;
  assign empty     = ~|vld;

  always_comb begin
    vld_nxt = vld;
    if (pop)  vld_nxt[head] = 1'b0;
    if (push) vld_nxt[tail] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= '0;
      head <= '0;
      tail <= '0;
    end else begin
      vld <= vld_nxt;
      if (push) tail <= step(tail);
      if (pop)  head <= step(head);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[tail] <= wr_addr;
      data_q[tail] <= wr_data;
      be_q[tail]   <= wr_be;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit[g] = vld[g] && (addr_q[g] == rd_chk_addr);
  end
  assign rd_hold = rd_chk_valid & |hit;

  // R4
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_be));

  // R5
  stall_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> $countones(vld) == DEPTH);

  // R5
  stall_no_enq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $countones(vld) == DEPTH && $stable(tail));

  // R9
  empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !mem_valid && !rd_hold && !stall);

  // R6
  full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&vld) && pop && wr_valid |=> (&vld));
endmodule

// File: tb/test_store_queue.sv
module test_store_queue;
  logic        clk = 0, rst_n = 0;
  logic        wr_valid = 0, mem_ready = 0, rd_chk_valid = 0;
  logic [31:0] wr_addr = 0, wr_data = 0, rd_chk_addr = 0;
  logic [3:0]  wr_be = 0;
  logic        stall, mem_valid, rd_hold, empty;
  logic [31:0] mem_addr, mem_data;
  logic [3:0]  mem_be;
  int checks = 0, errors = 0;

  store_queue i_store_queue (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .stall(stall), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_be(mem_be), .rd_chk_valid(rd_chk_valid), .rd_chk_addr(rd_chk_addr),
    .rd_hold(rd_hold), .empty(empty)
  );

  always #4 clk = ~clk;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] dat(input logic [31:0] a);
    return a ^ 32'hA5A5_0000;
  endfunction

  task automatic put(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
    wr_valid = 1; wr_addr = a; wr_data = d; wr_be = be;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic fill(input logic [31:0] base);
    for (int i = 0; i < 4; i++) put(base + 32'(4 * i), dat(base + 32'(4 * i)), 4'hF);
  endtask

  task automatic take(input string rq, input logic [31:0] a, input logic [31:0] d);
    mem_ready = 1; #1;
    chk({rq, " valid"}, {31'b0, mem_valid}, 1);
    chk({rq, " addr"}, mem_addr, a);
    chk({rq, " data"}, mem_data, d);
    @(negedge clk);
    mem_ready = 0;
  endtask

  task automatic t_reset;
    chk("R1 empty", {31'b0, empty}, 1);
    chk("R1 mem_valid", {31'b0, mem_valid}, 0);
    chk("R1 stall", {31'b0, stall}, 0);
  endtask

  task automatic t_single;
    put(32'h40, 32'hCAFE_0001, 4'b0110);
    chk("R2 valid", {31'b0, mem_valid}, 1);
    chk("R2 addr", mem_addr, 32'h40);
    chk("R10 be", {28'b0, mem_be}, 32'h6);
    chk("R9 not empty", {31'b0, empty}, 0);
    repeat (3) @(negedge clk);
    chk("R4 addr stable", mem_addr, 32'h40);
    chk("R4 data stable", mem_data, 32'hCAFE_0001);
    chk("R4 valid held", {31'b0, mem_valid}, 1);
    take("R3 single", 32'h40, 32'hCAFE_0001);
    chk("R9 empty after drain", {31'b0, empty}, 1);
  endtask

  task automatic t_stall;
    fill(32'h100);
    chk("R5 stall when full", {31'b0, stall}, 1);
    put(32'hDEAD_0000, 32'h0, 4'hF);
    chk("R5 still full", {31'b0, stall}, 1);
    for (int i = 0; i < 4; i++) take("R3 order", 32'h100 + 32'(4 * i), dat(32'h100 + 32'(4 * i)));
    chk("R5 dropped store absent", {31'b0, empty}, 1);
  endtask

  task automatic t_swap;
    fill(32'h200);
    wr_valid = 1; wr_addr = 32'h2F0; wr_data = dat(32'h2F0); wr_be = 4'hF;
    mem_ready = 1; #1;
    chk("R6 no stall on drain", {31'b0, stall}, 0);
    @(negedge clk);
    wr_valid = 0; mem_ready = 0; #1;
    chk("R6 still full", {31'b0, stall}, 1);
    for (int i = 1; i < 4; i++) take("R6 order", 32'h200 + 32'(4 * i), dat(32'h200 + 32'(4 * i)));
    take("R6 swapped entry", 32'h2F0, dat(32'h2F0));
    chk("R6 empty", {31'b0, empty}, 1);
  endtask

  task automatic t_hold;
    put(32'h300, dat(32'h300), 4'hF);
    put(32'h304, dat(32'h304), 4'hF);
    rd_chk_valid = 1; rd_chk_addr = 32'h304; #1;
    chk("R7 hold on match", {31'b0, rd_hold}, 1);
    rd_chk_addr = 32'h308; #1;
    chk("R7 no hold on miss", {31'b0, rd_hold}, 0);
    rd_chk_addr = 32'h304;
    take("R7 drain first", 32'h300, dat(32'h300));
    #1 chk("R7 hold kept", {31'b0, rd_hold}, 1);
    take("R7 drain match", 32'h304, dat(32'h304));
    #1 chk("R7 hold released", {31'b0, rd_hold}, 0);
    rd_chk_valid = 0;
  endtask

  task automatic t_dup;
    put(32'h500, 32'h1111_1111, 4'h1);
    put(32'h500, 32'h2222_2222, 4'h8);
    chk("R10 be first", {28'b0, mem_be}, 32'h1);
    take("R8 first", 32'h500, 32'h1111_1111);
    chk("R10 be second", {28'b0, mem_be}, 32'h8);
    take("R8 second", 32'h500, 32'h2222_2222);
    chk("R8 empty", {31'b0, empty}, 1);
  endtask

  initial begin
    #80000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    @(negedge clk);
    t_single;
    t_stall;
    t_swap;
    t_hold;
    t_dup;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule